// File: doc/BRIEF.md
# DMA Channel Interrupt Controller

This block collects the interrupt causes of one DMA channel and folds them into a single interrupt line. It keeps a 12-bit status register and a 12-bit mask register. Software reaches them over a simple 32-bit register bus.

Software clears status bits by writing ones to them. It cannot write the mask register directly. Instead, one write-only port clears mask bits and a second write-only port sets them. The data mover sends single-cycle event pulses into the block:

- one pulse per status cause;
- a source-descriptor completion pulse;
- a destination-descriptor completion pulse.

Each completion pulse advances an 8-bit accounting counter. Software reads a counter to learn how many completions happened since the last read, and that read also clears it. When a counter rolls over, the block sets an overflow cause in the status register.

A bus access is a single cycle with `bus_sel` high. Read data appears on `bus_rdata` one clock later and is zero in every other cycle. The interrupt line is registered. It reflects a status or mask change one clock after the write or event that caused it.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After a synchronous reset:
  - the status register is 0x000;
  - the mask register is 0xFFF;
  - both counters are 0;
  - `irq` is low.
- R2: A write to the status register at byte offset 0x00 clears each status bit whose data bit is 1 and leaves bits written as 0 unchanged. Bits 31..12 of the status register always read as zero.
- R3: A write to the mask register at offset 0x04 has no effect on the mask. Reading offset 0x04 returns the mask.
- R4: Writing a 1 to bit n of the unmask port (offset 0x08) clears mask bit n. Writing a 1 to bit n of the mask-set port (offset 0x0C) sets mask bit n. Reads of either port return 0.
- R5: `irq` is high exactly when some status bit is set whose mask bit is clear. It follows each status write, mask change or event one clock later.
- R6: Each `src_cmpl` pulse increments the source counter (read at offset 0x10) and sets status bit 1. Each `dst_cmpl` pulse increments the destination counter (read at offset 0x14) and sets status bit 2.
- R7: When a counter increments from 255 it becomes 0. For the source counter this also sets status bit 4; for the destination counter it sets status bit 5.
- R8: A read of a counter returns its value and clears it to zero. If a completion pulse arrives in the same cycle as the read, the read returns the old value and the counter becomes 1.
- R9: A read or write at any offset other than 0x00..0x14 sets status bit 0. A read of such an offset returns 0.
- R10: If a status write clears a bit in the same cycle that an event sets it, the bit ends up set.
- R11: A pulse on bit n of `ev_flag` sets status bit n. The status bits are:

  | Bit | Cause |
  |-----|-------|
  | 11 | pause |
  | 10 | done |
  | 9 | write-data error |
  | 8 | read-data error |
  | 7 | destination-descriptor read error |
  | 6 | source-descriptor read error |
  | 5 | destination-counter wrap |
  | 4 | source-counter wrap |
  | 3 | byte-count overflow |
  | 2 | destination-descriptor done |
  | 1 | source-descriptor done |
  | 0 | invalid access |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one clock after a read access |
| ev_flag | input | 12 | Single-cycle status-cause pulses from the data mover |
| src_cmpl | input | 1 | Source-descriptor completion pulse (interrupt requested) |
| dst_cmpl | input | 1 | Destination-descriptor completion pulse (interrupt requested) |
| irq | output | 1 | Channel interrupt line |

## Verification
Two functions can meet in one clock: a software action and a hardware event on the same state.

- **Status bit.** The bench drives a status write that clears bit 8 in the same cycle that `ev_flag[8]` pulses. It then reads the status back and expects bit 8 set and `irq` high.
- **Counter.** The bench issues a read of the source counter in the same cycle as a `src_cmpl` pulse. The scoreboard expects the old count, and a second read must return 1.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int unsigned NUM_CAUSE = 12;

  // Status bit positions, decoded by software
  localparam int unsigned B_BAD_ACC   = 0;
  localparam int unsigned B_SRC_DONE  = 1;
  localparam int unsigned B_DST_DONE  = 2;
  localparam int unsigned B_BYTE_OVF  = 3;
  localparam int unsigned B_SRC_WRAP  = 4;
  localparam int unsigned B_DST_WRAP  = 5;
  localparam int unsigned B_SRC_FETCH = 6;
  localparam int unsigned B_DST_FETCH = 7;
  localparam int unsigned B_RD_ERR    = 8;
  localparam int unsigned B_WR_ERR    = 9;
  localparam int unsigned B_XFER_DONE = 10;
  localparam int unsigned B_PAUSED    = 11;

  // Word index of each register (byte offset / 4)
  localparam int unsigned WI_STATUS  = 0;
  localparam int unsigned WI_MASK    = 1;
  localparam int unsigned WI_UNMASK  = 2;
  localparam int unsigned WI_MASKSET = 3;
  localparam int unsigned WI_SRC_CNT = 4;
  localparam int unsigned WI_DST_CNT = 5;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_STATUS,
    RS_MASK,
    RS_UNMASK,
    RS_MASKSET,
    RS_SRC_CNT,
    RS_DST_CNT
  } reg_sel_e;

endpackage

// File: rtl/dma_irq_regdec.sv
module dma_irq_regdec
  import dma_irq_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic [IDX_W-1:0] word_idx,
  output reg_sel_e         sel
);

  always_comb begin
    case (int'(word_idx))
      WI_STATUS:  sel = RS_STATUS;
      WI_MASK:    sel = RS_MASK;
      WI_UNMASK:  sel = RS_UNMASK;
      WI_MASKSET: sel = RS_MASKSET;
      WI_SRC_CNT: sel = RS_SRC_CNT;
      WI_DST_CNT: sel = RS_DST_CNT;
      default:    sel = RS_NONE;
    endcase
  end

endmodule

// File: rtl/dma_irq_acct_cnt.sv
module dma_irq_acct_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             incr,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);

  logic [CNT_W-1:0] base;

  // A read in this cycle returns cnt_q; the increment lands on the cleared value
  always_comb begin
    base = rd_clr ? '0 : cnt_q;
    wrap = incr && (base == {CNT_W{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= base + CNT_W'(incr);
  end

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int unsigned NUM = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] w1c,
  input  logic [NUM-1:0] set_vec,
  input  logic [NUM-1:0] unmask,
  input  logic [NUM-1:0] maskset,
  output logic [NUM-1:0] status_q,
  output logic [NUM-1:0] mask_q,
  output logic           irq_q
);

  logic [NUM-1:0] status_n;
  logic [NUM-1:0] mask_n;

  // Events are ORed in after the clear, so they win a same-cycle collision
  always_comb begin
    status_n = (status_q & ~w1c) | set_vec;
    mask_n   = (mask_q & ~unmask) | maskset;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_n;
      mask_q   <= mask_n;
      irq_q    <= |(status_n & ~mask_n);
    end
  end

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_CAUSE-1:0] ev_flag,
  input  logic                 src_cmpl,
  input  logic                 dst_cmpl
  ,output logic                irq
);

  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned NUM_CH = 2;

  reg_sel_e sel;
  logic     wr_acc;
  logic     rd_acc;

  logic [NUM_CAUSE-1:0] w1c;
  logic [NUM_CAUSE-1:0] unmask;
  logic [NUM_CAUSE-1:0] maskset;
  logic [NUM_CAUSE-1:0] set_vec;
  logic [NUM_CAUSE-1:0] status_q;
  logic [NUM_CAUSE-1:0] mask_q;

  logic [NUM_CH-1:0] cnt_incr;
  logic [NUM_CH-1:0] cnt_clr;
  logic [NUM_CH-1:0] cnt_wrap;
  logic [CNT_W-1:0]  cnt_val [NUM_CH];
  logic [CNT_W-1:0]  src_cnt_q;
  logic [CNT_W-1:0]  dst_cnt_q;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:NUM_CAUSE]};

  assign wr_acc = bus_sel && bus_wr;
  assign rd_acc = bus_sel && !bus_wr;

  dma_irq_regdec #(.IDX_W(IDX_W)) u_dec (
    .word_idx (bus_addr[ADDR_W-1:2]),
    .sel      (sel)
  );

  assign w1c     = (wr_acc && sel == RS_STATUS)  ? bus_wdata[NUM_CAUSE-1:0] : '0;
  assign unmask  = (wr_acc && sel == RS_UNMASK)  ? bus_wdata[NUM_CAUSE-1:0] : '0;
  assign maskset = (wr_acc && sel == RS_MASKSET) ? bus_wdata[NUM_CAUSE-1:0] : '0;

  // Channel 0 accounts source completions, channel 1 destination completions
  assign cnt_incr = {dst_cmpl, src_cmpl};
  assign cnt_clr  = {rd_acc && sel == RS_DST_CNT, rd_acc && sel == RS_SRC_CNT};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_acct
    dma_irq_acct_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .incr   (cnt_incr[g]),
      .rd_clr (cnt_clr[g]),
      .cnt_q  (cnt_val[g]),
      .wrap   (cnt_wrap[g])
    );
  end

  assign src_cnt_q = cnt_val[0];
  assign dst_cnt_q = cnt_val[1];

  always_comb begin
    set_vec             = ev_flag;
    set_vec[B_SRC_DONE] = ev_flag[B_SRC_DONE] | src_cmpl;
    set_vec[B_DST_DONE] = ev_flag[B_DST_DONE] | dst_cmpl;
    set_vec[B_SRC_WRAP] = ev_flag[B_SRC_WRAP] | cnt_wrap[0];
    set_vec[B_DST_WRAP] = ev_flag[B_DST_WRAP] | cnt_wrap[1];
    set_vec[B_BAD_ACC]  = ev_flag[B_BAD_ACC]  | (bus_sel && sel == RS_NONE);
  end

  dma_irq_status #(.NUM(NUM_CAUSE)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .w1c      (w1c),
    .set_vec  (set_vec),
    .unmask   (unmask),
    .maskset  (maskset),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq_q    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_acc) begin
      case (sel)
        RS_STATUS:  bus_rdata <= DATA_W'(status_q);
        RS_MASK:    bus_rdata <= DATA_W'(mask_q);
        RS_SRC_CNT: bus_rdata <= DATA_W'(src_cnt_q);
        RS_DST_CNT: bus_rdata <= DATA_W'(dst_cnt_q);
        default:    bus_rdata <= '0;
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end

endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned NUM    = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM-1:0]    ev_flag,
  input logic              src_cmpl,
  input logic              irq,
  input logic [NUM-1:0]    status_q,
  input logic [NUM-1:0]    mask_q,
  input logic [CNT_W-1:0]  src_cnt_q
);

  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_MASK   = IDX_W'(dma_irq_pkg::WI_MASK);
  localparam logic [IDX_W-1:0] I_UNMASK = IDX_W'(dma_irq_pkg::WI_UNMASK);
  localparam logic [IDX_W-1:0] I_SRC    = IDX_W'(dma_irq_pkg::WI_SRC_CNT);
  localparam logic [IDX_W-1:0] I_LAST   = IDX_W'(dma_irq_pkg::WI_DST_CNT);

  logic [IDX_W-1:0] idx;
  assign idx = bus_addr[ADDR_W-1:2];

  p_irq_level_r5: assert property (@(posedge clk) disable iff (rst)
    irq == |(status_q & ~mask_q));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:NUM] == '0);

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && idx == I_MASK) |=> $stable(mask_q));

  p_unmask_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && idx == I_UNMASK) |=> ((mask_q & $past(bus_wdata[NUM-1:0])) == '0));

  p_event_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (ev_flag != '0) |=> ((status_q & $past(ev_flag)) == $past(ev_flag)));

  p_bad_access_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && idx > I_LAST) |=> status_q[0]);

  p_read_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && idx == I_SRC && !src_cmpl) |=> (src_cnt_q == '0));

endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .NUM    (dma_irq_pkg::NUM_CAUSE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ev_flag   (ev_flag),
  .src_cmpl  (src_cmpl),
  .irq       (irq),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .src_cnt_q (src_cnt_q)
);

// File: tb/test_dma_irq_ctrl.sv
`timescale 1ns/1ps
module test_dma_irq_ctrl;

  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [11:0]   ev_flag = '0;
  logic          src_cmpl = 1'b0;
  logic          dst_cmpl = 1'b0;
  logic          irq;

  int   n_run  = 0;
  int   n_fail = 0;
  logic rd_seen = 1'b0;
  bit   finished = 0;

  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #2 clk = ~clk;

  dma_irq_ctrl i_dma_irq_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_flag(ev_flag), .src_cmpl(src_cmpl), .dst_cmpl(dst_cmpl), .irq(irq)
  );

  always @(posedge clk) rd_seen <= bus_sel && !bus_wr;

  // Monitor: pop the expected read value once the registered data is out
  logic [DW-1:0] m_exp;
  string         m_tag;
  always @(negedge clk) begin
    if (rd_seen) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read data: actual %h expected none", bus_rdata);
      end else begin
        m_exp = exp_q.pop_front();
        m_tag = tag_q.pop_front();
        if (bus_rdata !== m_exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", m_tag, bus_rdata, m_exp);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_run++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s irq: actual %b expected %b", tag, irq, e);
    end
  endtask

  task automatic pulse_flag(input logic [11:0] f);
    ev_flag = f;
    @(negedge clk);
    ev_flag = '0;
  endtask

  task automatic pulse_src(input int n);
    for (int i = 0; i < n; i++) begin
      src_cmpl = 1'b1; @(negedge clk); src_cmpl = 1'b0;
    end
  endtask

  task automatic pulse_dst(input int n);
    for (int i = 0; i < n; i++) begin
      dst_cmpl = 1'b1; @(negedge clk); dst_cmpl = 1'b0;
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired (all requirements)");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    rd(8'h00, 32'h000, "R1 status");
    rd(8'h04, 32'hFFF, "R1 mask");
    rd(8'h10, 32'h0,   "R1 src count");
    rd(8'h14, 32'h0,   "R1 dst count");
    chk_irq(1'b0, "R1");

    // R11 flag input sets status; masked so R5 keeps irq low
    pulse_flag(12'h400);
    chk_irq(1'b0, "R5 masked");
    rd(8'h00, 32'h400, "R11 status");

    // R4 unmask, R5 irq rises
    wr(8'h08, 32'h400);
    chk_irq(1'b1, "R5 unmasked");
    rd(8'h04, 32'hBFF, "R4 mask after unmask");
    rd(8'h08, 32'h0,   "R4 unmask port reads 0");

    // R2 write-one-to-clear
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h400, "R2 zero write keeps");
    wr(8'h00, 32'hFFFF_F400);
    chk_irq(1'b0, "R5 after clear");
    rd(8'h00, 32'h0, "R2 cleared");

    // R3 mask not writable; R4 mask-set port
    wr(8'h04, 32'h0);
    rd(8'h04, 32'hBFF, "R3 mask unchanged");
    wr(8'h0C, 32'h400);
    rd(8'h04, 32'hFFF, "R4 mask after set");
    rd(8'h0C, 32'h0,   "R4 set port reads 0");

    // R6 completions, R8 read-clear
    pulse_src(3);
    rd(8'h10, 32'd3, "R6 src count");
    rd(8'h10, 32'd0, "R8 src cleared");
    pulse_dst(1);
    rd(8'h14, 32'd1, "R6 dst count");
    rd(8'h00, 32'h006, "R6 done bits");

    // R7 destination wrap
    wr(8'h00, 32'hFFF);
    pulse_dst(256);
    rd(8'h00, 32'h024, "R7 dst wrap bit");
    rd(8'h14, 32'd0,   "R7 dst count wrapped");

    // R7 source wrap
    wr(8'h00, 32'hFFF);
    pulse_src(256);
    rd(8'h00, 32'h012, "R7 src wrap bit");

    // R8 read and completion in the same cycle
    rd(8'h10, 32'd0, "R8 src after wrap");
    pulse_src(2);
    exp_q.push_back(32'd2); tag_q.push_back("R8 old value on collision");
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h10; src_cmpl = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; src_cmpl = 1'b0;
    rd(8'h10, 32'd1, "R8 count after collision");

    // R9 undecoded offsets
    wr(8'h00, 32'hFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h00, 32'h001, "R9 write sets bit 0");
    rd(8'hFC, 32'h0,   "R9 undecoded read is 0");

    // R10 event beats a same-cycle clear
    wr(8'h00, 32'hFFF);
    wr(8'h08, 32'hFFF);
    chk_irq(1'b0, "R5 all unmasked no cause");
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h100; ev_flag = 12'h100;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; ev_flag = '0;
    chk_irq(1'b1, "R10");
    rd(8'h00, 32'h100, "R10 bit stays set");
    wr(8'h00, 32'h100);
    chk_irq(1'b0, "R2 irq drops after clear");

    repeat (2) @(negedge clk);
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finished = 1;
    summary();
    $finish;
  end

endmodule